// File: doc/BRIEF.md
# Per-Core Banked Timer Register Router

This block sits between a 32-bit register bus and an array of timer and watchdog instances. There is one timer and one watchdog for each processor core, and the block supports 1 to 4 cores. The address space is cut into 32-byte windows. The two lowest windows are aliases that are resolved at run time from the core ID that comes with each access. Window 0 reaches the requester's own timer, and window 1 reaches the requester's own watchdog. The windows above them give fixed access to every instance, interleaved timer then watchdog, core by core. Through these, any core can reach any instance.

The router forwards a one-hot select, the write flag, the in-window offset and the write data to the instances. It captures the selected instance's read data in a register and returns it one cycle after the request, together with an error flag. It also collects the instances' interrupt lines into one output vector in a fixed order. The instances themselves are outside the block.

Top module: `ptr_router`

## Requirements
- R1: Window 0 (address bits above bit 4 equal 0) selects instance 2*c, and window 1 selects instance 2*c+1, where c is `req_core_id`.
- R2: Window w with 2 <= w < 2+2*NCORE selects instance w-2. Instance 2n is the timer of core n and instance 2n+1 is its watchdog. At most one select bit is ever high.
- R3: The window number is `req_addr >> 5`. `inst_off` carries `req_addr` modulo 32 unchanged, and `inst_wdata` and `inst_write` carry the request's data and direction.
- R4: An access to window 0 or 1 with `req_core_id >= NCORE` raises `rsp_err`. It selects no instance, so a write changes nothing, and a read returns zero.
- R5: An access to a window at or above 2+2*NCORE selects no instance and returns zero with `rsp_err` low.
- R6: Only word accesses are valid: `req_size` must be 2'b10 (4 bytes). Any other size raises `rsp_err`, selects nothing and returns zero.
- R7: `rsp_valid` is high exactly in the cycle after a request cycle. `rsp_rdata` is the selected instance's read data sampled in the request cycle, and is zero for writes. After reset, all response outputs are zero.
- R8: `irq_out[i]` follows `inst_irq[i]` with no delay, in the order timer core 0, watchdog core 0, timer core 1, watchdog core 1, and so on.
- R9: NCORE is a parameter limited to 1 through 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (9) | Byte address; bits above 4 are the window number |
| req_size | input | 2 | Access size code; 2'b10 = 4 bytes |
| req_core_id | input | CORE_W (2) | ID of the requesting core |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Registered read data |
| inst_sel | output | 2*NCORE (8) | One-hot instance select |
| inst_write | output | 1 | Write flag to the instances |
| inst_off | output | 5 | Offset within the window |
| inst_wdata | output | 32 | Write data to the instances |
| inst_rdata | input | 2*NCORE*32 (256) | Read data from each instance, instance i in bits 32i+31..32i |
| inst_irq | input | 2*NCORE (8) | Interrupt line of each instance |
| irq_out | output | 2*NCORE (8) | Collected interrupt vector |

## Verification
The bench keeps its own register stubs behind every instance port. A directed pass writes a distinct value through each direct window and reads it back through the alias windows for every core. This separates the timer alias from the watchdog alias, and a swapped or misscaled core index from a correct one. Faulty accesses (out-of-range alias core ID, wrong size, a void window) are each followed by a read through a valid window. That read shows the stub kept its old value, which separates "error flagged" from "access also blocked". A seeded random mix of addresses, sizes, core IDs and directions, with nonzero low offset bits, then exercises offset routing and the one-cycle read latency against a reference model held in the bench.

// File: rtl/ptr_pkg.sv
package ptr_pkg;

    // Byte width of one register window and the bits that address inside it
    localparam int WIN_BYTES = 32;
    localparam int OFF_W     = $clog2(WIN_BYTES);
    // Size code of the only legal access width (4 bytes)
    localparam logic [1:0] SIZE_WORD = 2'b10;
    // Number of alias windows placed below the direct windows
    localparam int ALIAS_WINS = 2;
    localparam int MAX_CORES  = 4;

    typedef enum logic [1:0] {
        RT_IDLE  = 2'd0,
        RT_INST  = 2'd1,
        RT_VOID  = 2'd2,
        RT_FAULT = 2'd3
    } route_kind_e;

    // Instance index reached through an alias window
    function automatic int alias_index(input int core, input logic is_wdog);
        return 2 * core + (is_wdog ? 1 : 0);
    endfunction

endpackage

// File: rtl/ptr_decode.sv
module ptr_decode
    import ptr_pkg::*;
#(
    parameter int NCORE  = 4,
    parameter int ADDR_W = 9,
    parameter int CORE_W = 2,
    parameter int IDX_W  = 3
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [CORE_W-1:0] core_id,
    output route_kind_e       kind,
    output logic [IDX_W-1:0]  idx
);
    localparam int NINST = 2 * NCORE;
    localparam int WIN_W = ADDR_W - OFF_W;

    logic [WIN_W-1:0] win;
    int               win_i;
    int               core_i;

    always_comb begin
        win    = addr[ADDR_W-1:OFF_W];
        win_i  = int'(win);
        core_i = int'(core_id);
        kind   = RT_IDLE;
        idx    = '0;
        if (valid) begin
            if (size != SIZE_WORD) begin
                kind = RT_FAULT;
            end else if (win_i < ALIAS_WINS) begin
                if (core_i >= NCORE) begin
                    kind = RT_FAULT;
                end else begin
                    kind = RT_INST;
                    idx  = IDX_W'(alias_index(core_i, win[0]));
                end
            end else if (win_i < NINST + ALIAS_WINS) begin
                kind = RT_INST;
                idx  = IDX_W'(win_i - ALIAS_WINS);
            end else begin
                kind = RT_VOID;
            end
        end
    end

endmodule

// File: rtl/ptr_fanout.sv
module ptr_fanout
    import ptr_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int IDX_W = 3
) (
    input  route_kind_e            kind,
    input  logic [IDX_W-1:0]       idx,
    input  logic [2*NCORE*32-1:0]  inst_rdata,
    input  logic [2*NCORE-1:0]     inst_irq,
    output logic [2*NCORE-1:0]     inst_sel,
    output logic [31:0]            sel_rdata,
    output logic [2*NCORE-1:0]     irq_out
);
    localparam int NINST = 2 * NCORE;

    logic [NINST-1:0][31:0] word;

    for (genvar g = 0; g < NINST; g++) begin : g_lane
        assign word[g]     = inst_rdata[g*32 +: 32];
        assign inst_sel[g] = (kind == RT_INST) && (int'(idx) == g);
        // instance order on the bus equals output bit order
        assign irq_out[g]  = inst_irq[g];
    end

    always_comb begin
        sel_rdata = '0;
        for (int i = 0; i < NINST; i++) begin
            if (inst_sel[i]) sel_rdata = word[i];
        end
    end

    // R2
    sel_onehot_chk: assert final ($onehot0(inst_sel));

endmodule

// File: rtl/ptr_resp.sv
module ptr_resp
    import ptr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  route_kind_e kind,
    input  logic [31:0] sel_rdata,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [31:0] rsp_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && (kind == RT_FAULT);
            rsp_rdata <= (req_valid && !req_write && kind == RT_INST) ? sel_rdata : '0;
        end
    end

    // R7
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R7
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_err && rsp_rdata == '0));
    // R7
    wr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |=> rsp_rdata == '0);

endmodule

// File: rtl/ptr_router.sv
module ptr_router
    import ptr_pkg::*;
#(
    parameter int NCORE  = 4,
    parameter int ADDR_W = 9,
    parameter int CORE_W = 2,
    localparam int NINST = 2 * NCORE,
    localparam int IDX_W = (NINST > 1) ? $clog2(NINST) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [1:0]            req_size,
    input  logic [CORE_W-1:0]     req_core_id,
    input  logic [31:0]           req_wdata,
    output logic                  rsp_valid,
    output logic                  rsp_err,
    output logic [31:0]           rsp_rdata,
    output logic [NINST-1:0]      inst_sel,
    output logic                  inst_write,
    output logic [OFF_W-1:0]      inst_off,
    output logic [31:0]           inst_wdata,
    input  logic [NINST*32-1:0]   inst_rdata,
    input  logic [NINST-1:0]      inst_irq,
    output logic [NINST-1:0]      irq_out
);
    // R9
    if (NCORE < 1 || NCORE > MAX_CORES) begin : g_bad_ncore
        $error("NCORE out of range");
    end

    route_kind_e      kind;
    logic [IDX_W-1:0] idx;
    logic [31:0]      sel_rdata;

    ptr_decode #(
        .NCORE(NCORE), .ADDR_W(ADDR_W), .CORE_W(CORE_W), .IDX_W(IDX_W)
    ) u_decode (
        .valid(req_valid), .addr(req_addr), .size(req_size),
        .core_id(req_core_id), .kind(kind), .idx(idx)
    );

    ptr_fanout #(.NCORE(NCORE), .IDX_W(IDX_W)) u_fanout (
        .kind(kind), .idx(idx), .inst_rdata(inst_rdata), .inst_irq(inst_irq),
        .inst_sel(inst_sel), .sel_rdata(sel_rdata), .irq_out(irq_out)
    );

    ptr_resp u_resp (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .kind(kind), .sel_rdata(sel_rdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    assign inst_write = req_write;
    assign inst_off   = req_addr[OFF_W-1:0];
    assign inst_wdata = req_wdata;

    logic [ADDR_W-OFF_W-1:0] win_num;
    assign win_num = req_addr[ADDR_W-1:OFF_W];

    // R4
    alias_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && int'(win_num) < ALIAS_WINS && int'(req_core_id) >= NCORE)
        |-> (inst_sel == '0));
    // R4
    alias_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && int'(win_num) < ALIAS_WINS && int'(req_core_id) >= NCORE)
        |=> (rsp_err && rsp_rdata == '0));
    // R6
    size_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size != SIZE_WORD) |=> (rsp_err && rsp_rdata == '0));
    // R5
    void_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && int'(win_num) >= NINST + ALIAS_WINS) |-> (inst_sel == '0));
    // R2
    direct_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == SIZE_WORD && int'(win_num) >= ALIAS_WINS
         && int'(win_num) < NINST + ALIAS_WINS) |-> $countones(inst_sel) == 1);

endmodule

// File: tb/ptr_router_bench.sv
module ptr_router_bench;
    localparam int NC = 3;
    localparam int NI = 2 * NC;
    localparam int AW = 9;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           req_valid = 1'b0;
    logic           req_write = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic [1:0]     req_size = 2'b10;
    logic [1:0]     req_core_id = '0;
    logic [31:0]    req_wdata = '0;
    logic           rsp_valid, rsp_err;
    logic [31:0]    rsp_rdata;
    logic [NI-1:0]  inst_sel;
    logic           inst_write;
    logic [4:0]     inst_off;
    logic [31:0]    inst_wdata;
    logic [NI*32-1:0] inst_rdata;
    logic [NI-1:0]  inst_irq = '0;
    logic [NI-1:0]  irq_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] stub  [NI][8];
    logic [31:0] model [NI][8];

    always #10 clk = ~clk;   // 50 MHz

    ptr_router #(.NCORE(NC), .ADDR_W(AW), .CORE_W(2)) u_ptr_router (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_core_id(req_core_id),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .inst_sel(inst_sel), .inst_write(inst_write),
        .inst_off(inst_off), .inst_wdata(inst_wdata), .inst_rdata(inst_rdata),
        .inst_irq(inst_irq), .irq_out(irq_out)
    );

    // register stubs standing in for the timer instances
    always_ff @(posedge clk) begin
        for (int i = 0; i < NI; i++) begin
            if (rst) begin
                for (int j = 0; j < 8; j++) stub[i][j] <= '0;
            end else if (inst_sel[i] && inst_write) begin
                stub[i][inst_off[4:2]] <= inst_wdata;
            end
        end
    end
    for (genvar g = 0; g < NI; g++) begin : g_stub
        assign inst_rdata[g*32 +: 32] = stub[g][inst_off[4:2]];
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // kind: 0 = instance, 1 = void window, 2 = error
    function automatic void route(input logic [AW-1:0] a, input logic [1:0] sz,
                                  input logic [1:0] cid, output int kind, output int idx);
        int w;
        w = int'(a) / 32;
        idx = 0;
        if (sz != 2'b10) kind = 2;
        else if (w < 2) begin
            if (int'(cid) >= NC) kind = 2;
            else begin kind = 0; idx = 2 * int'(cid) + w; end
        end else if (w < 2 + NI) begin kind = 0; idx = w - 2; end
        else kind = 1;
    endfunction

    task automatic access(input bit w, input logic [AW-1:0] a, input logic [1:0] sz,
                          input logic [1:0] cid, input logic [31:0] d, input string req);
        int kind, idx;
        logic [NI-1:0] esel;
        logic [31:0] erd;
        route(a, sz, cid, kind, idx);
        esel = (kind == 0) ? NI'(1) << idx : '0;
        erd  = (kind == 0 && !w) ? model[idx][a[4:2]] : 32'h0;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz;
        req_core_id = cid; req_wdata = d;
        #1;
        chk(inst_sel == esel, req, "select", 32'(inst_sel), 32'(esel));
        chk(inst_off == a[4:0] && inst_wdata == d && inst_write == w, "R3", "offset",
            32'(inst_off), 32'(a[4:0]));
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R7", "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(rsp_err == (kind == 2), req, "rsp_err", 32'(rsp_err), 32'(kind == 2));
        chk(rsp_rdata == erd, req, "rsp_rdata", rsp_rdata, erd);
        if (w && kind == 0) model[idx][a[4:2]] = d;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        for (int i = 0; i < NI; i++) for (int j = 0; j < 8; j++) model[i][j] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk(rsp_valid == 0 && rsp_err == 0 && rsp_rdata == 0, "R7", "reset",
            rsp_rdata, 32'h0);

        // R2: fill every instance through its direct window
        for (int k = 0; k < NI; k++)
            access(1'b1, AW'((2 + k) * 32 + 4), 2'b10, 2'd0, 32'hA000_0000 + k, "R2");
        // R1: read own timer and watchdog through the aliases for every core
        for (int c = 0; c < NC; c++) begin
            access(1'b0, AW'(4), 2'b10, 2'(c), 32'h0, "R1");
            access(1'b0, AW'(32 + 4), 2'b10, 2'(c), 32'h0, "R1");
        end
        // R1: alias write lands in the core's own watchdog
        access(1'b1, AW'(32 + 8), 2'b10, 2'd2, 32'hCAFE_0002, "R1");
        access(1'b0, AW'((2 + 5) * 32 + 8), 2'b10, 2'd0, 32'h0, "R1");
        // R4: out-of-range core ID through an alias
        access(1'b1, AW'(4), 2'b10, 2'd3, 32'hDEAD_0004, "R4");
        access(1'b0, AW'(32 + 4), 2'b10, 2'd3, 32'h0, "R4");
        for (int k = 0; k < NI; k++)
            access(1'b0, AW'((2 + k) * 32 + 4), 2'b10, 2'd1, 32'h0, "R4");
        // R5: void window
        access(1'b1, AW'(12 * 32 + 4), 2'b10, 2'd0, 32'hBEEF_0005, "R5");
        access(1'b0, AW'(15 * 32 + 4), 2'b10, 2'd0, 32'h0, "R5");
        // R6: wrong sizes are blocked
        access(1'b1, AW'(2 * 32 + 4), 2'b01, 2'd0, 32'h1111_0006, "R6");
        access(1'b0, AW'(2 * 32 + 4), 2'b00, 2'd0, 32'h0, "R6");
        access(1'b0, AW'(2 * 32 + 4), 2'b10, 2'd0, 32'h0, "R6");
        // R7: no response in an idle cycle
        @(negedge clk);
        chk(rsp_valid == 0 && rsp_err == 0, "R7", "idle", 32'(rsp_valid), 32'h0);
        // R8: interrupt lines
        for (int n = 0; n < 8; n++) begin
            inst_irq = (n == 0) ? NI'(1) : NI'($urandom);
            #1;
            chk(irq_out == inst_irq, "R8", "irq", 32'(irq_out), 32'(inst_irq));
        end
        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [1:0] sz;
            sz = ($urandom % 8 == 0) ? 2'($urandom) : 2'b10;
            access(1'($urandom), AW'($urandom), sz, 2'($urandom), $urandom, "R2");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule